// File: doc/BRIEF.md
# Per-Pin Input Qualification Filter

This block cleans up sixteen input pins before the rest of the chip sees them. Each pin has its own 2-bit filter mode that can be changed at run time. In the sync-only mode the pin passes through a two-flop synchronizer. In the two qualification modes a new level is accepted only after several samples in a row agree: three samples in one mode, six in the other. In the bypass mode the raw pin goes straight to the output. Bypass applies only to pins that a peripheral uses. A pin that is used as a general-purpose input falls back to sync-only when set to bypass.

A shared sampling-period register sets how far apart the qualification samples are. A small register port writes and reads the mode-select word and the period. Writes take effect only while the write-unlock input is high. Reads are always allowed. Whenever a pin's effective mode changes, its sample history is cleared and its output holds its current level until the new mode accepts a level.

Top module: `inqual_bank`

## Requirements
- R1: Pin n takes its mode from bits [2n+1:2n] of the select word. The codes are: 00 sync-only, 01 three-sample qualification, 10 six-sample qualification, 11 bypass.
- R2: While reset is high, the select word, the period and every qualified output go to 0, and a read on the next cycle returns 0.
- R3: In sync-only mode a pin's output equals its raw input from three clock edges earlier (two synchronizer flops and the output register).
- R4: In three-sample mode the output takes a new level only at a sample that makes the last three samples equal to that level. Otherwise it holds its value, so a pulse seen by fewer than three samples is dropped.
- R5: In six-sample mode the same rule applies over the last six samples.
- R6: A period value of 0 takes a qualification sample on every clock. A value P greater than 0 takes one every 2×P clocks. The period is held in bits [7:0] of address 1.
- R7: In bypass mode on a peripheral pin (its configuration bit is 0), the output equals the raw input in the same cycle, with no register on the path.
- R8: In bypass mode on a general-purpose pin (its configuration bit is 1), the pin behaves exactly as in sync-only mode.
- R9: A write to address 0 (the select word) or address 1 (the period) is ignored unless wr_unlock is high on the same cycle. Read data appears one cycle after the address is presented.
- R10: When a pin's effective mode changes, its sample history is cleared and its output holds until the new mode's agreement rule is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = select word, 1 = sampling period |
| reg_wdata | input | 32 | Write data |
| wr_unlock | input | 1 | Write protection enable; writes apply only while high |
| reg_rdata | output | 32 | Registered read data |
| pin_is_gpio | input | 16 | Per-pin usage: 1 = general-purpose input, 0 = peripheral |
| pin_raw | input | 16 | Raw pin levels |
| pin_qual | output | 16 | Qualified pin levels |

## Verification
A wrong history count or stale sample window shows up as an output edge that is early or late by whole sample periods. It also shows up as a short pulse that gets through when it should be dropped. A lane comparison catches these within one sample period of the faulty edge. A strobe counter that wraps at the wrong count moves every qualified edge. The error therefore shows on all qualifying pins within a few periods of a level change. A mode-change tracker that fails to clear history lets a pin switch on samples taken under the old mode. This is visible in the first few samples after the mode write.

// File: rtl/inqual_pkg.sv
package inqual_pkg;
  typedef enum logic [1:0] {
    QM_SYNC   = 2'b00,
    QM_Q3     = 2'b01,
    QM_Q6     = 2'b10,
    QM_BYPASS = 2'b11
  } qmode_e;

  localparam int HIST_DEPTH = 6;
  localparam int CNT_W      = 3;
endpackage

// File: rtl/inqual_regs.sv
module inqual_regs #(
  parameter int NUM_PINS = 16,
  parameter int PERIOD_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic                  reg_addr,
  input  logic [2*NUM_PINS-1:0] reg_wdata,
  input  logic                  wr_unlock,
  output logic [2*NUM_PINS-1:0] sel_q,
  output logic [PERIOD_W-1:0]   period_q,
  output logic [2*NUM_PINS-1:0] reg_rdata
);
  localparam int DW = 2 * NUM_PINS;

  logic wr_ok;
  assign wr_ok = reg_we && wr_unlock;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      period_q  <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_addr) reg_rdata <= DW'(period_q);
      else          reg_rdata <= sel_q;
      if (wr_ok && !reg_addr) sel_q    <= reg_wdata;
      if (wr_ok &&  reg_addr) period_q <= reg_wdata[PERIOD_W-1:0];
    end
  end
endmodule

// File: rtl/inqual_strobe.sv
module inqual_strobe #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period,
  output logic                strobe
);
  localparam int CW = PERIOD_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  always_comb begin
    limit  = {period, 1'b0} - CW'(1);
    strobe = (period == '0) || (cnt_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (strobe) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/inqual_sync.sv
module inqual_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/inqual_lane.sv
module inqual_lane
  import inqual_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       is_gpio,
  input  logic       smp_in,
  input  logic       strobe,
  output logic       qual_q
);
  qmode_e eff_mode, prev_q;
  logic [HIST_DEPTH-1:0] hist_q, hist_nx;
  logic [CNT_W-1:0]      hcnt_q, hcnt_nx;
  logic agree3, agree6, accept;

  always_comb begin
    if (mode == QM_BYPASS && is_gpio) eff_mode = QM_SYNC;
    else                              eff_mode = qmode_e'(mode);
    hist_nx = {hist_q[HIST_DEPTH-2:0], smp_in};
    hcnt_nx = (hcnt_q == CNT_W'(HIST_DEPTH)) ? hcnt_q : hcnt_q + CNT_W'(1);
    agree3  = (hcnt_nx >= CNT_W'(3)) &&
              ((hist_nx[2:0] == 3'b000) || (hist_nx[2:0] == 3'b111));
    agree6  = (hcnt_nx >= CNT_W'(6)) &&
              ((hist_nx[5:0] == 6'b000000) || (hist_nx[5:0] == 6'b111111));
    accept  = (eff_mode == QM_Q3) ? agree3 : agree6;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= QM_SYNC;
      hist_q <= '0;
      hcnt_q <= '0;
      qual_q <= 1'b0;
    end else if (eff_mode != prev_q) begin
      prev_q <= eff_mode;
      hist_q <= '0;
      hcnt_q <= '0;
    end else begin
      case (eff_mode)
        QM_Q3, QM_Q6: begin
          if (strobe) begin
            hist_q <= hist_nx;
            hcnt_q <= hcnt_nx;
            if (accept) qual_q <= hist_nx[0];
          end
        end
        default: qual_q <= smp_in;
      endcase
    end
  end
endmodule

// File: rtl/inqual_bank.sv
module inqual_bank
  import inqual_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int PERIOD_W    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic                reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  input  logic                wr_unlock,
  output logic [DW-1:0]       reg_rdata,
  input  logic [NUM_PINS-1:0] pin_is_gpio,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_qual
);
  logic [DW-1:0]       sel_q;
  logic [PERIOD_W-1:0] period_q;
  logic                smp_strobe;
  logic [NUM_PINS-1:0] sync_q;
  logic [NUM_PINS-1:0] lane_q;

  inqual_regs #(.NUM_PINS(NUM_PINS), .PERIOD_W(PERIOD_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wr_unlock(wr_unlock),
    .sel_q(sel_q), .period_q(period_q), .reg_rdata(reg_rdata)
  );

  inqual_strobe #(.PERIOD_W(PERIOD_W)) u_strobe (
    .clk(clk), .rst(rst), .period(period_q), .strobe(smp_strobe)
  );

  inqual_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(sync_q)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_lane
      logic bypass;
      inqual_lane u_lane (
        .clk(clk), .rst(rst), .mode(sel_q[2*i +: 2]),
        .is_gpio(pin_is_gpio[i]), .smp_in(sync_q[i]),
        .strobe(smp_strobe), .qual_q(lane_q[i])
      );
      assign bypass      = (sel_q[2*i +: 2] == QM_BYPASS) && !pin_is_gpio[i];
      assign pin_qual[i] = bypass ? pin_raw[i] : lane_q[i];
    end
  endgenerate
endmodule

// File: rtl/inqual_chk.sv
module inqual_chk #(
  parameter int NUM_PINS = 16,
  parameter int PERIOD_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_we,
  input logic                  wr_unlock,
  input logic [2*NUM_PINS-1:0] sel_q,
  input logic [PERIOD_W-1:0]   period_q,
  input logic                  strobe,
  input logic [NUM_PINS-1:0]   qual_q
);
  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (sel_q == '0 && period_q == '0));

  a_r9_locked_write: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !wr_unlock) |=> ($stable(sel_q) && $stable(period_q)));

  a_r6_every_clock: assert property (@(posedge clk) disable iff (rst)
    (period_q == '0) |-> strobe);

  a_r6_spaced: assert property (@(posedge clk) disable iff (rst)
    (strobe && period_q != '0) |=> (!strobe || period_q == '0));

  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_pin
      // R4 and R5: a qualifying lane only moves on a sample strobe
      a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!strobe && (sel_q[2*i +: 2] == 2'b01 || sel_q[2*i +: 2] == 2'b10))
        |=> $stable(qual_q[i]));
    end
  endgenerate
endmodule

bind inqual_bank inqual_chk #(.NUM_PINS(NUM_PINS), .PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .wr_unlock(wr_unlock),
  .sel_q(sel_q), .period_q(period_q), .strobe(smp_strobe), .qual_q(lane_q)
);

// File: tb/tb_inqual_bank.sv
module tb_inqual_bank;
  localparam int NP = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_addr = 1'b0, wr_unlock = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NP-1:0] pin_is_gpio = '0, pin_raw = '0, pin_qual;

  always #2.5 clk = ~clk;

  inqual_bank dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wr_unlock(wr_unlock), .reg_rdata(reg_rdata),
    .pin_is_gpio(pin_is_gpio), .pin_raw(pin_raw), .pin_qual(pin_qual)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [DW-1:0] m_sel, m_rd;
  logic [7:0]    m_per;
  int            m_cnt;
  logic [NP-1:0] m_s1, m_s2, m_out;
  logic [5:0]    m_hist [NP];
  int            m_hc   [NP];
  logic [1:0]    m_prev [NP];

  function automatic void model_reset();
    m_sel = '0; m_rd = '0; m_per = '0; m_cnt = 0;
    m_s1 = '0; m_s2 = '0; m_out = '0;
    for (int i = 0; i < NP; i++) begin
      m_hist[i] = '0; m_hc[i] = 0; m_prev[i] = 2'b00;
    end
  endfunction

  function automatic void model_step();
    bit stb;
    stb = (m_per == 0) || (m_cnt >= 2 * int'(m_per) - 1);
    for (int i = 0; i < NP; i++) begin
      logic [1:0] md, eff;
      md  = m_sel[2*i +: 2];
      eff = (md == 2'b11 && pin_is_gpio[i]) ? 2'b00 : md;
      if (eff != m_prev[i]) begin
        m_prev[i] = eff; m_hist[i] = '0; m_hc[i] = 0;
      end else if (eff == 2'b01 || eff == 2'b10) begin
        if (stb) begin
          logic [5:0] nh, mask;
          int nc, need;
          nh   = {m_hist[i][4:0], m_s2[i]};
          nc   = (m_hc[i] >= 6) ? 6 : m_hc[i] + 1;
          need = (eff == 2'b01) ? 3 : 6;
          mask = (eff == 2'b01) ? 6'b000111 : 6'b111111;
          if (nc >= need && ((nh & mask) == 0 || (nh & mask) == mask))
            m_out[i] = nh[0];
          m_hist[i] = nh; m_hc[i] = nc;
        end
      end else begin
        m_out[i] = m_s2[i];
      end
    end
    m_rd = reg_addr ? {24'd0, m_per} : m_sel;
    if (reg_we && wr_unlock) begin
      if (reg_addr) m_per = reg_wdata[7:0];
      else          m_sel = reg_wdata;
    end
    m_cnt = stb ? 0 : m_cnt + 1;
    m_s2 = m_s1;
    m_s1 = pin_raw;
  endfunction

  function automatic logic [NP-1:0] exp_qual();
    logic [NP-1:0] e;
    for (int i = 0; i < NP; i++)
      e[i] = (m_sel[2*i +: 2] == 2'b11 && !pin_is_gpio[i]) ? pin_raw[i] : m_out[i];
    return e;
  endfunction

  function automatic string req_of(int pin);
    logic [1:0] md;
    md = m_sel[2*pin +: 2];
    if (md == 2'b00) return "R3";
    if (md == 2'b01) return "R4";
    if (md == 2'b10) return "R5";
    return pin_is_gpio[pin] ? "R8" : "R7";
  endfunction

  task automatic check(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic check_pins();
    logic [NP-1:0] e;
    e = exp_qual();
    n_chk++;
    if (pin_qual !== e) begin
      int p = 0;
      for (int i = NP - 1; i >= 0; i--) if (pin_qual[i] !== e[i]) p = i;
      n_bad++;
      $display("FAIL %s (pin %0d, R10 if just switched) actual=%h expected=%h at %0t",
               req_of(p), p, pin_qual, e, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d, input logic unl);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; wr_unlock = unl;
    tick();
    reg_we = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic rd_check(input logic a, input string rq);
    reg_addr = a;
    tick();
    check(rq, reg_rdata, m_rd);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] seen;
    void'($urandom(32'h1D5E_0C4A));
    model_reset();
    repeat (4) tick();
    rst = 1'b0;
    // R2 reset state
    check("R2", {16'd0, pin_qual}, '0);
    rd_check(1'b0, "R2");
    check("R2", reg_rdata, '0);
    rd_check(1'b1, "R2");
    // R9 locked write ignored
    wr(1'b0, 32'hFFFF_FFFF, 1'b0);
    rd_check(1'b0, "R9");
    check("R9", reg_rdata, '0);
    wr(1'b1, 32'h0000_0005, 1'b0);
    rd_check(1'b1, "R9");
    // R1 / R7: only pin 5 in bypass (bits 11:10)
    wr(1'b0, 32'h0000_0C00, 1'b1);
    rd_check(1'b0, "R9");
    pin_raw = 16'h0060;
    #1;
    check("R7", {31'd0, pin_qual[5]}, 32'd1);
    check("R1", {31'd0, pin_qual[6]}, 32'd0);
    // R8: same pin as gpio follows sync path
    pin_is_gpio[5] = 1'b1;
    #1;
    check_pins();
    repeat (4) begin tick(); check_pins(); end
    check("R8", {31'd0, pin_qual[5]}, 32'd1);
    pin_is_gpio = '0;
    pin_raw = '0;
    // R4: pin 1 three-sample, period 0, 2-cycle glitch dropped
    wr(1'b0, 32'h0000_0004, 1'b1);
    repeat (8) begin tick(); check_pins(); end
    pin_raw[1] = 1'b1; tick(); check_pins(); tick(); check_pins();
    pin_raw[1] = 1'b0;
    repeat (8) begin tick(); check_pins(); end
    check("R4", {31'd0, pin_qual[1]}, 32'd0);
    // R4: 3-cycle pulse accepted
    seen = '0;
    pin_raw[1] = 1'b1;
    repeat (3) begin tick(); check_pins(); seen |= pin_qual; end
    pin_raw[1] = 1'b0;
    repeat (8) begin tick(); check_pins(); seen |= pin_qual; end
    check("R4", {31'd0, seen[1]}, 32'd1);
    // R5 + R6: pin 2 six-sample, period 2
    wr(1'b1, 32'd2, 1'b1);
    wr(1'b0, 32'h0000_0020, 1'b1);
    pin_raw[2] = 1'b1;
    repeat (60) begin tick(); check_pins(); end
    check("R5", {31'd0, pin_qual[2]}, 32'd1);
    rd_check(1'b1, "R6");
    // R10: mode change holds output
    wr(1'b0, 32'h0000_0010, 1'b1);
    pin_raw[2] = 1'b0;
    tick();
    check("R10", {31'd0, pin_qual[2]}, 32'd1);
    repeat (20) begin tick(); check_pins(); end
    // random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 59) == 0)
        wr(1'b0, $urandom(), 1'($urandom_range(0, 3) != 0));
      else if ($urandom_range(0, 149) == 0)
        wr(1'b1, 32'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0));
      else if ($urandom_range(0, 199) == 0)
        rd_check(1'($urandom_range(0, 1)), "R9");
      else begin
        if ($urandom_range(0, 99) == 0) pin_is_gpio = 16'($urandom());
        for (int i = 0; i < NP; i++)
          if ($urandom_range(0, 9) == 0) pin_raw[i] = ~pin_raw[i];
        #1;
        check_pins();
        tick();
      end
      check_pins();
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule